// File: doc/BRIEF.md
# Split-Precision Adder with Grouped Look-Ahead Upper Half

This combinational block adds two unsigned operands of `WIDTH` bits and trades accuracy in the low half for a short carry path. The lower `WIDTH/2` result bits are formed bit by bit as the logical OR of the operand bits. No carry is formed there, and none is passed upward. The upper `WIDTH/2` bits are added exactly by a row of 4-bit slices. Inside each slice the carries come from grouped generate/propagate terms. The slice carry-in joins only at the last AND-OR level, so each slice adds one AND plus one OR of delay between its carry-in and its carries.

The result is `WIDTH+1` bits wide, and its top bit is the carry out of the highest slice. Because the low half drops exactly the bits where both operands are set, the result is never above the true sum. It falls short of the true sum by less than `2**(WIDTH/2)`. The block suits datapaths that tolerate small errors, such as pixel accumulation.

Top module: `apx_pc_adder`

## Requirements
- R1: For every bit position i below WIDTH/2, result bit i equals opnd_a[i] OR opnd_b[i].
- R2: Result bits WIDTH-1 down to WIDTH/2 equal the low WIDTH/2 bits of the exact sum of the upper operand halves. No carry enters them from the low half, even when both low halves are all ones.
- R3: Result bit WIDTH (the top bit) is the carry out of the exact sum of the upper operand halves.
- R4: Each 4-bit slice produces a 5-bit value {carry-out, sum} equal to a + b + carry-in. Its carries come from grouped generate (a AND b) and propagate (a XOR b) terms.
- R5: The carry out of each slice is the carry-in of the next slice up. The carry-in of the lowest slice is 0.
- R6: The true sum minus the result equals the AND of the two low operand halves. The error is therefore below 2**(WIDTH/2).
- R7: The result never exceeds the true sum opnd_a + opnd_b.
- R8: When the low operand halves share no set bit, the result equals the true sum exactly.
- R9: Zero operands give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First unsigned operand |
| opnd_b | input | WIDTH | Second unsigned operand |
| sum_o | output | WIDTH+1 | Approximate sum; the top bit is the carry out of the upper half |

## Verification
The embedded checks assume fully known operand values. They also assume WIDTH is a multiple of 8, so that the upper half splits evenly into 4-bit slices. Each check skips evaluation while any operand bit is X or Z. The bench holds the default WIDTH of 16, drives every operand bit with a defined value from the first clock edge, and changes operands only on rising edges. The arithmetic relations are therefore checked only on settled, known inputs.

// File: rtl/apx_add_pkg.sv
package apx_add_pkg;
  localparam int unsigned SLICE_W = 4;

  function automatic int unsigned slice_count(input int unsigned width);
    return (width / 2) / SLICE_W;
  endfunction
endpackage

// File: rtl/apx_or_lower.sv
module apx_or_lower #(
  parameter int unsigned HALF_W = 8
) (
  input  logic [HALF_W-1:0] lo_a,
  input  logic [HALF_W-1:0] lo_b,
  output logic [HALF_W-1:0] lo_sum
);
  // Carry-free low half: one OR gate per bit, nothing leaves upward.
  for (genvar i = 0; i < HALF_W; i++) begin : g_bit
    assign lo_sum[i] = lo_a[i] | lo_b[i];
  end
endmodule

// File: rtl/pcla_slice4.sv
module pcla_slice4
  import apx_add_pkg::*;
(
  input  logic [SLICE_W-1:0] sa,
  input  logic [SLICE_W-1:0] sb,
  input  logic               cin,
  output logic [SLICE_W-1:0] ssum,
  output logic               cout
);
  logic [SLICE_W-1:0] prp;
  logic [SLICE_W-1:0] gen;
  logic               grp10, grp20, grp32, grp30;
  logic               pp10, pp20, pp30;
  logic [SLICE_W:0]   cy;

  always_comb begin
    prp   = sa ^ sb;
    gen   = sa & sb;
    // group generates, independent of cin
    grp10 = gen[1] | (prp[1] & gen[0]);
    grp20 = gen[2] | (prp[2] & gen[1]) | (prp[2] & prp[1] & gen[0]);
    grp32 = gen[3] | (prp[3] & gen[2]);
    grp30 = grp32 | (prp[3] & prp[2] & grp10);
    // propagate products formed alongside the group generates
    pp10  = prp[1] & prp[0];
    pp20  = prp[2] & pp10;
    pp30  = prp[3] & prp[2] & pp10;
    // cin enters only at the last AND-OR level
    cy[0] = cin;
    cy[1] = gen[0] | (prp[0] & cin);
    cy[2] = grp10  | (pp10 & cin);
    cy[3] = grp20  | (pp20 & cin);
    cy[4] = grp30  | (pp30 & cin);
    ssum  = prp ^ cy[SLICE_W-1:0];
    cout  = cy[SLICE_W];
  end

  always_comb begin
    if (!$isunknown({sa, sb, cin})) begin
      AST_SLICE_SUM: assert ({cout, ssum} == (5'(sa) + 5'(sb) + 5'(cin)))
        else $error("slice result mismatch"); // R4
    end
  end
endmodule

// File: rtl/pcla_chain.sv
module pcla_chain
  import apx_add_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic [HALF_W-1:0] hi_a,
  input  logic [HALF_W-1:0] hi_b,
  output logic [HALF_W-1:0] hi_sum,
  output logic              hi_cout
);
  localparam int unsigned NSLICE = HALF_W / SLICE_W;

  logic [NSLICE:0] link;

  assign link[0] = 1'b0;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    pcla_slice4 u_slice (
      .sa   (hi_a[k*SLICE_W +: SLICE_W]),
      .sb   (hi_b[k*SLICE_W +: SLICE_W]),
      .cin  (link[k]),
      .ssum (hi_sum[k*SLICE_W +: SLICE_W]),
      .cout (link[k+1])
    );
  end

  assign hi_cout = link[NSLICE];

  always_comb begin
    if (!$isunknown({hi_a, hi_b})) begin
      AST_CHAIN_EXACT: assert ({hi_cout, hi_sum} == ((HALF_W+1)'(hi_a) + (HALF_W+1)'(hi_b)))
        else $error("upper half not exact"); // R5
    end
  end
endmodule

// File: rtl/apx_pc_adder.sv
module apx_pc_adder
  import apx_add_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH:0]   sum_o
);
  localparam int unsigned HALF_W = WIDTH / 2;

  logic [HALF_W-1:0] lo_res;
  logic [HALF_W-1:0] hi_res;
  logic              hi_co;

  apx_or_lower #(.HALF_W(HALF_W)) u_lower (
    .lo_a   (opnd_a[HALF_W-1:0]),
    .lo_b   (opnd_b[HALF_W-1:0]),
    .lo_sum (lo_res)
  );

  pcla_chain #(.HALF_W(HALF_W)) u_upper (
    .hi_a    (opnd_a[WIDTH-1:HALF_W]),
    .hi_b    (opnd_b[WIDTH-1:HALF_W]),
    .hi_sum  (hi_res),
    .hi_cout (hi_co)
  );

  assign sum_o = {hi_co, hi_res, lo_res};

  logic [WIDTH:0] true_sum;
  logic [WIDTH:0] shortfall;

  always_comb begin
    true_sum  = (WIDTH+1)'(opnd_a) + (WIDTH+1)'(opnd_b);
    shortfall = true_sum - sum_o;
    if (!$isunknown({opnd_a, opnd_b})) begin
      AST_NEVER_ABOVE: assert (sum_o <= true_sum)
        else $error("result above true sum"); // R7
      AST_ERR_BOUND: assert (shortfall < ((WIDTH+1)'(1) << HALF_W))
        else $error("error bound exceeded"); // R6
      AST_ERR_SHAPE: assert (shortfall == (WIDTH+1)'(opnd_a[HALF_W-1:0] & opnd_b[HALF_W-1:0]))
        else $error("error not equal to low AND"); // R6
    end
  end
endmodule

// File: tb/apx_pc_adder_tb.sv
module apx_pc_adder_tb_top;
  localparam int W = 16;
  localparam int H = W / 2;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [W:0]   s;
  int           n_chk;
  int           n_fail;
  bit           done;

  apx_pc_adder #(.WIDTH(W)) dut_i (.opnd_a(a), .opnd_b(b), .sum_o(s));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [H:0] hi;
    hi = (H+1)'(x[W-1:H]) + (H+1)'(y[W-1:H]);
    return {hi, x[H-1:0] | y[H-1:0]};
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    a = x;
    b = y;
    @(negedge clk);
  endtask

  task automatic t_zero;
    apply('0, '0);
    check("R9", s, '0);
  endtask

  task automatic t_low_or;
    apply(16'h00A5, 16'h005A);
    check("R1", {9'b0, s[H-1:0]}, 17'h000FF);
    apply(16'h00F0, 16'h00F0);
    check("R1", {9'b0, s[H-1:0]}, 17'h000F0);
  endtask

  task automatic t_no_low_carry;
    apply(16'h12FF, 16'h34FF);
    check("R2", {8'b0, s[W:H]}, 17'h00046);
  endtask

  task automatic t_top_carry;
    apply(16'hFF00, 16'h0100);
    check("R3", s, 17'h10000);
    apply(16'hFFFF, 16'hFFFF);
    check("R3", s, 17'h1FEFF);
  endtask

  task automatic t_slices;
    for (int i = 0; i < 16; i++) begin
      apply(16'(i << H), 16'((15 - i) << H) | 16'h1000);
      check("R4", s, model(a, b));
    end
  endtask

  task automatic t_cross_slice;
    apply(16'h0F00, 16'h0100);
    check("R5", s, 17'h01000);
    apply(16'h7F00, 16'h0100);
    check("R5", s, 17'h08000);
  endtask

  task automatic t_error;
    logic [W:0] tru;
    apply(16'h00FF, 16'h00FF);
    tru = (W+1)'(a) + (W+1)'(b);
    check("R6", tru - s, 17'h000FF);
    for (int i = 0; i < 2000; i++) begin
      apply(16'($urandom), 16'($urandom));
      tru = (W+1)'(a) + (W+1)'(b);
      check("R6", s, model(a, b));
      check("R6", tru - s, (W+1)'(a[H-1:0] & b[H-1:0]));
      check("R7", {16'b0, s <= tru}, 17'd1);
    end
  endtask

  task automatic t_exact_when_disjoint;
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] x;
      x = 16'($urandom);
      apply(x, 16'($urandom) & ~(16'(x[H-1:0])));
      check("R8", s, (W+1)'(a) + (W+1)'(b));
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    a = '0;
    b = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_zero();
    t_low_or();
    t_no_low_carry();
    t_top_carry();
    t_slices();
    t_cross_slice();
    t_error();
    t_exact_when_disjoint();
    done = 1'b1;
    finish_up();
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finish_up();
    end
  end
endmodule